// File: doc/BRIEF.md
# Segment-Table Address Translator

This block turns a two-part logical address into a physical address. The upper three bits of a 16-bit logical address pick one of eight segments, and the remaining thirteen bits give the offset within that segment. A small table on the chip holds, for each segment, a starting physical address (the base), a segment length (the limit) and a present flag. When an offset falls inside its segment, the block returns the base plus the offset. When the offset does not fit, the segment is absent, or the sum runs past the top of the 16-bit physical space, it raises an addressing trap and returns no address.

Software or a supervisor loads the table through a write port that updates one entry per cycle. A translation request is taken in one cycle, and the answer appears on the following cycle.

A three-state response machine holds the answer. `RS_IDLE` means no request was taken. `RS_GRANT` means a legal translation, and `RS_FAULT` means a trap. On every clock edge the machine moves from whichever state it is in: to `RS_GRANT` on a legal request (transition *accept*), to `RS_FAULT` on an illegal request (transition *reject*), and to `RS_IDLE` when there is no request (transition *quiet*). Reset forces `RS_IDLE`.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is taken from logical address bits 15:13 and the offset from bits 12:0, so segment 7 with offset 8191 is address 16'hFFFF.
- R2: Reset clears the present flag of every entry and drives `rs_valid`, `rs_trap` and `rs_paddr` to zero. A translation of any segment after reset traps until that entry is written again.
- R3: When `wr_en` is high at a clock edge, entry `wr_idx` takes `wr_base`, `wr_limit` and `wr_present`. The other entries are left unchanged.
- R4: One cycle after a request (`rq_valid` high), exactly one of `rs_valid` and `rs_trap` is high. On a legal request `rs_valid` is high and `rs_paddr` equals base plus offset.
- R5: An offset greater than or equal to the entry's limit traps. An offset of limit minus one is legal, and a limit of zero traps every offset.
- R6: A request to an entry whose present flag is 0 traps, whatever its base and limit.
- R7: If base plus offset carries out of bit 15, the request traps and no address is given.
- R8: `rs_valid` and `rs_trap` are never high together. Both are low the cycle after a cycle without a request, and `rs_paddr` is zero whenever `rs_valid` is low.
- R9: A write and a translation of the same entry in the same cycle translate using the entry's old contents. The new contents apply from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | 3 | Entry to write |
| wr_base | input | 16 | Base physical address to store |
| wr_limit | input | 14 | Segment length to store |
| wr_present | input | 1 | Present flag to store |
| rq_valid | input | 1 | Translation request |
| rq_addr | input | 16 | Logical address: segment in 15:13, offset in 12:0 |
| rs_valid | output | 1 | Legal translation, one cycle after the request |
| rs_trap | output | 1 | Addressing trap, one cycle after the request |
| rs_paddr | output | 16 | Physical address, zero unless `rs_valid` |

## Verification
The bench checks offsets at the limit and one below it. A design that compares with less-than-or-equal would grant the first of these, and one that compares off by one would trap the second. It also uses a zero limit, absent entries, and a sum that lands exactly on 16'hFFFF next to one that carries. A design that dropped the carry would hand back a wrapped low address. A write and a translation of the same entry are issued in one cycle to catch a bypass that applies the new base early. A reset in mid-run shows whether stale present flags survive.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_SEG_W  = 3;
    localparam int DEF_LIM_W  = 14;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_GRANT = 2'd1,
        RS_FAULT = 2'd2
    } rs_state_t;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int N_SEG  = 8,
    parameter int ADDR_W = 16,
    parameter int LIM_W  = 14,
    localparam int IDX_W = $clog2(N_SEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic              wr_present,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              rd_present
);
    logic [ADDR_W-1:0] base_q [N_SEG];
    logic [LIM_W-1:0]  lim_q  [N_SEG];
    logic              pres_q [N_SEG];

    for (genvar g = 0; g < N_SEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                lim_q[g]  <= '0;
                pres_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                base_q[g] <= wr_base;
                lim_q[g]  <= wr_limit;
                pres_q[g] <= wr_present;
            end
        end
    end

    // read sees the contents from before this edge's write
    always_comb begin
        rd_base    = base_q[rd_idx];
        rd_limit   = lim_q[rd_idx];
        rd_present = pres_q[rd_idx];
    end
endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 13,
    parameter int LIM_W  = 14
) (
    input  logic              present,
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic [OFF_W-1:0]  offset,
    output logic              legal,
    output logic [ADDR_W-1:0] paddr
);
    logic [ADDR_W:0] sum;
    logic            in_range;

    always_comb begin
        in_range = {{(LIM_W-OFF_W){1'b0}}, offset} < limit;
        sum      = {1'b0, base} + {{(ADDR_W+1-OFF_W){1'b0}}, offset};
        legal    = present && in_range && !sum[ADDR_W];
        paddr    = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int SEG_W  = DEF_SEG_W,
    parameter int LIM_W  = DEF_LIM_W,
    localparam int OFF_W = ADDR_W - SEG_W,
    localparam int N_SEG = 1 << SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic              wr_present,
    input  logic              rq_valid,
    input  logic [ADDR_W-1:0] rq_addr,
    output logic              rs_valid,
    output logic              rs_trap,
    output logic [ADDR_W-1:0] rs_paddr
);
    logic [SEG_W-1:0]  rq_seg;
    logic [OFF_W-1:0]  rq_off;
    logic [ADDR_W-1:0] ent_base;
    logic [LIM_W-1:0]  ent_limit;
    logic              ent_present;
    logic              legal;
    logic [ADDR_W-1:0] sum_addr;

    rs_state_t         state_q, state_d;
    logic [ADDR_W-1:0] paddr_q, paddr_d;

    assign rq_seg = rq_addr[ADDR_W-1:OFF_W];
    assign rq_off = rq_addr[OFF_W-1:0];

    seg_table #(.N_SEG(N_SEG), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_base    (wr_base),
        .wr_limit   (wr_limit),
        .wr_present (wr_present),
        .rd_idx     (rq_seg),
        .rd_base    (ent_base),
        .rd_limit   (ent_limit),
        .rd_present (ent_present)
    );

    seg_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LIM_W(LIM_W)) u_check (
        .present (ent_present),
        .base    (ent_base),
        .limit   (ent_limit),
        .offset  (rq_off),
        .legal   (legal),
        .paddr   (sum_addr)
    );

    // next state: accept / reject / quiet
    always_comb begin
        state_d = RS_IDLE;
        paddr_d = '0;
        if (rq_valid) begin
            if (legal) begin
                state_d = RS_GRANT;
                paddr_d = sum_addr;
            end else begin
                state_d = RS_FAULT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            paddr_q <= paddr_d;
        end
    end

    always_comb begin
        rs_valid = 1'b0;
        rs_trap  = 1'b0;
        rs_paddr = '0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_GRANT: begin
                rs_valid = 1'b1;
                rs_paddr = paddr_q;
            end
            RS_FAULT: rs_trap = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rq_valid,
    input logic              rs_valid,
    input logic              rs_trap,
    input logic [ADDR_W-1:0] rs_paddr
);
    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rs_valid && rs_trap));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rq_valid |=> (!rs_valid && !rs_trap));

    // R4
    resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |=> (rs_valid || rs_trap));

    // R8
    pzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (rs_paddr == '0));

    // R2
    rst_out_chk: assert property (@(posedge clk)
        !rst_n |=> (!rs_valid && !rs_trap && rs_paddr == '0));
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W)) u_seg_xlate_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rq_valid (rq_valid),
    .rs_valid (rs_valid),
    .rs_trap  (rs_trap),
    .rs_paddr (rs_paddr)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_base = '0;
    logic [13:0] wr_limit = '0;
    logic        wr_present = 1'b0;
    logic        rq_valid = 1'b0;
    logic [15:0] rq_addr = '0;
    logic        rs_valid;
    logic        rs_trap;
    logic [15:0] rs_paddr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model of the table
    logic [15:0] m_base [8];
    logic [13:0] m_lim  [8];
    logic        m_pres [8];

    // scoreboard queues: kind 0 idle, 1 grant, 2 trap
    int          q_kind [$];
    logic [15:0] q_addr [$];
    string       q_tag  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate i_seg_xlate (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_limit(wr_limit), .wr_present(wr_present),
        .rq_valid(rq_valid), .rq_addr(rq_addr),
        .rs_valid(rs_valid), .rs_trap(rs_trap), .rs_paddr(rs_paddr)
    );

    task automatic model_clear();
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_pres[i] = 1'b0;
        end
    endtask

    task automatic check(input string tag, input bit ok,
                         input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, pushes the expectation
    task automatic step(input bit we, input int wi, input logic [15:0] wb,
                        input logic [13:0] wl, input bit wp,
                        input bit rv, input logic [15:0] ra, input string tag);
        int          kind;
        logic [16:0] sum;
        int          seg;
        logic [12:0] off;
        @(negedge clk);
        wr_en = we; wr_idx = 3'(wi); wr_base = wb; wr_limit = wl; wr_present = wp;
        rq_valid = rv; rq_addr = ra;
        seg = int'(ra[15:13]);
        off = ra[12:0];
        sum = {1'b0, m_base[seg]} + {4'b0, off};
        if (!rv) kind = 0;
        else if (!m_pres[seg] || {1'b0, off} >= m_lim[seg] || sum[16]) kind = 2;
        else kind = 1;
        q_kind.push_back(kind);
        q_addr.push_back(kind == 1 ? sum[15:0] : 16'h0);
        q_tag.push_back(tag);
        @(posedge clk);
        if (we) begin
            m_base[wi] = wb; m_lim[wi] = wl; m_pres[wi] = wp;
        end
    endtask

    task automatic wr(input int wi, input logic [15:0] wb,
                      input logic [13:0] wl, input bit wp);
        step(1, wi, wb, wl, wp, 0, 16'h0, "R3");
    endtask

    task automatic rq(input int seg, input int off, input string tag);
        step(0, 0, 16'h0, 14'h0, 0, 1, {3'(seg), 13'(off)}, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q_kind.size() > 0) begin
                int k;
                logic [15:0] a;
                string t;
                k = q_kind.pop_front();
                a = q_addr.pop_front();
                t = q_tag.pop_front();
                check(t, rs_valid == (k == 1) && rs_trap == (k == 2) && rs_paddr == a,
                      $sformatf("v=%0b t=%0b pa=%h", rs_valid, rs_trap, rs_paddr),
                      $sformatf("v=%0b t=%0b pa=%h", k == 1, k == 2, a));
            end
        end
    end

    task automatic drain();
        repeat (2) step(0, 0, 16'h0, 14'h0, 0, 0, 16'h0, "R8 idle");
        @(negedge clk);
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 outputs after reset
        check("R2 reset outputs", !rs_valid && !rs_trap && rs_paddr == 0,
              $sformatf("v=%0b t=%0b pa=%h", rs_valid, rs_trap, rs_paddr), "v=0 t=0 pa=0000");

        rq(0, 0, "R2 absent after reset");
        rq(5, 3, "R2 absent after reset");
        step(0, 0, 16'h0, 14'h0, 0, 0, 16'h0, "R8 idle after request");

        wr(1, 16'h2000, 14'd100, 1);
        rq(1, 5, "R4 grant base+off");
        rq(1, 99, "R5 offset limit-1 legal");
        rq(1, 100, "R5 offset at limit traps");
        rq(1, 8191, "R5 large offset traps");

        wr(2, 16'h0400, 14'd0, 1);
        rq(2, 0, "R5 zero limit traps");

        wr(3, 16'hFF00, 14'd16383, 1);
        rq(3, 16'hFF, "R7 sum reaches FFFF legal");
        rq(3, 16'h100, "R7 carry traps");

        wr(7, 16'h1234, 14'd8192, 1);
        rq(7, 8191, "R1 top segment full offset");
        wr(0, 16'h0000, 14'd8192, 1);
        rq(0, 8191, "R1 segment 0 offset bits");

        wr(4, 16'h5000, 14'd50, 0);
        rq(4, 1, "R6 absent entry traps");

        // R9 same-cycle write and translate
        step(1, 5, 16'h6000, 14'd20, 1, 1, {3'd5, 13'd4}, "R9 old absent entry used");
        rq(5, 4, "R9 new entry next cycle");
        step(1, 1, 16'h8000, 14'd100, 1, 1, {3'd1, 13'd7}, "R9 old base used");
        rq(1, 7, "R9 new base next cycle");
        rq(7, 1, "R3 other entry unchanged");

        step(0, 0, 16'h0, 14'h0, 0, 0, 16'h0, "R8 idle");
        rq(5, 19, "R4 back-to-back");
        rq(5, 20, "R5 back-to-back trap");
        drain();

        // R2 mid-run reset clears present flags
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        rq(1, 7, "R2 entry cleared by reset");
        rq(7, 1, "R2 entry cleared by reset");
        drain();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule